// File: doc/BRIEF.md
# Delay-Line Calibration Scheduler

This block is the register front end and run scheduler for the calibration of a programmable delay line. It holds a control word and a configuration word behind a 32-bit register port with a single address bit. It starts calibration runs either from a software trigger or from a periodic timer. The timer interval is picked by a two-bit code. Each run goes to an external measurement engine through a start pulse and a done strobe. When a run completes, the engine returns a buffer count and a half-clock-period measurement.

The delay handed to the delay line (`dly_out`) mirrors the actual-delay field. That field can be loaded from a completed calibration or written directly. A direct write always wins. An inhibit bit freezes the field against calibration results, while measurements go on. A use-direct-delay bit stops every calibration trigger, so a written value stays in force. A trigger that arrives while a run is in progress waits in a single pending slot. Triggers beyond that one are dropped.

Top module: `dlcal_sched`

## Requirements
- R1: After reset the control word (address 0) reads 0x00000021: auto-calibration enabled, period code 01. The configuration word (address 1) reads 0.
- R2: Control word layout is bit 7 recalibrate/busy, bit 6 use-direct-delay, bit 5 auto enable, bit 4 update inhibit and bits 1:0 period code. Bits 31:8 and 3:2 always read 0, and writes to them have no effect.
- R3: A control write with bit 7 = 1 and bit 6 = 0 raises `meas_start` for the cycle after the write edge. Bit 7 reads 1 until that run's `meas_done`, then reads 0.
- R4: On `meas_done` during a run, config bits 15:8 take `meas_bufs` and bits 31:24 take `meas_half`. Bits 7:0 also take `meas_bufs`, and `dly_out` always equals bits 7:0.
- R5: A config write stores bits 23:16 (target, driven on `meas_target`) and bits 7:0 (actual delay). Bits 31:24 and 15:8 of the write are ignored.
- R6: With the inhibit bit set, a completed run updates config bits 15:8 and 31:24 but leaves bits 7:0 and `dly_out` unchanged.
- R7: With auto enabled, codes 00, 01 and 10 start a run every P0, P1 and P2 cycles respectively. The first start comes exactly P cycles after the control write or reset release. Code 11 never starts a run.
- R8: Any control write restarts the period count from zero.
- R9: While use-direct-delay is 1, neither a software nor a periodic trigger starts a run, and bit 7 does not read 1.
- R10: A trigger during a run is held and starts in the cycle after `meas_done`. At most one trigger is held, and further triggers are dropped.
- R11: A config write in the same cycle as a completed run sets bits 7:0 to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 control, 1 configuration |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| meas_start | output | 1 | One-cycle pulse that starts a measurement |
| meas_target | output | 8 | Software delay target passed to the engine |
| meas_done | input | 1 | Measurement complete strobe |
| meas_bufs | input | 8 | Measured buffer count, valid with `meas_done` |
| meas_half | input | 8 | Half-period measurement, valid with `meas_done` |
| dly_out | output | 8 | Applied delay to the delay line |

## Verification
The software trigger is swept over eighteen targets with engine latencies of one to six cycles. This separates results that are captured correctly from results taken at the wrong strobe, and shows whether the busy bit clears on the right run. Each period code is run with a short engine latency and the start times are compared against exact multiples of the interval. A mid-interval rewrite separates a restarted count from a free-running one. A latency longer than the interval floods the pending slot, which separates queue-one behaviour from no queueing or unbounded queueing. Inhibit, direct-write collision and use-direct-delay patterns each check that one of the three delay sources is overridden by the one that should win.

// File: rtl/dlcal_pkg.sv
// Shared field positions, types and reset values for the delay-line
// calibration scheduler. Assumes a 32-bit register word split into four
// 8-bit configuration fields.
package dlcal_pkg;
    localparam int REG_W   = 32;
    localparam int FIELD_W = REG_W / 4;

    // Control word bit positions (software decodes these)
    localparam int B_RECAL = 7;
    localparam int B_USE   = 6;
    localparam int B_AUTO  = 5;
    localparam int B_INH   = 4;

    typedef enum logic [1:0] {
        PER_SHORT = 2'b00,
        PER_MID   = 2'b01,
        PER_LONG  = 2'b10,
        PER_OFF   = 2'b11
    } per_code_e;

    typedef struct packed {
        logic      use_act;
        logic      auto_en;
        logic      inhibit;
        per_code_e period;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{use_act: 1'b0, auto_en: 1'b1,
                                   inhibit: 1'b0, period: PER_MID};
endpackage

// File: rtl/dlcal_period_timer.sv
// Periodic trigger source. Counts system clocks while auto-calibration is
// enabled and emits a one-cycle fire when the selected interval elapses.
// Assumes P0 < P1 < P2, each at least 2. Code 11 holds the count at zero.
module dlcal_period_timer #(
    parameter int P0 = 10000,
    parameter int P1 = 1000000,
    parameter int P2 = 10000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  dlcal_pkg::per_code_e period,
    input  logic                 restart,
    output logic                 fire
);
    import dlcal_pkg::*;

    localparam int CNT_W = $clog2(P2);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             active;

    // Select the terminal count for the current period code
    always_comb begin
        case (period)
            PER_SHORT: limit = CNT_W'(P0 - 1);
            PER_MID:   limit = CNT_W'(P1 - 1);
            PER_LONG:  limit = CNT_W'(P2 - 1);
            default:   limit = '0;
        endcase
    end

    assign active = enable && (period != PER_OFF);
    assign fire   = active && !restart && (cnt == limit);

    // Interval counter: cleared on restart, when idle, or at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !active || cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dlcal_run_ctrl.sv
// Run sequencer. Starts one measurement at a time, holds at most one
// trigger that arrives during a run and tracks whether a software request
// is outstanding. Assumes meas_done is not raised in the start cycle.
module dlcal_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_trig,
    input  logic per_trig,
    input  logic meas_done,
    output logic meas_start,
    output logic busy,
    output logic pend,
    output logic recal_busy
);
    logic run_sw;
    logic sw_req;
    logic trig;

    assign trig       = sw_trig || per_trig;
    assign recal_busy = sw_req || (busy && run_sw);

    // Start, complete and queue runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            pend       <= 1'b0;
            run_sw     <= 1'b0;
            sw_req     <= 1'b0;
            meas_start <= 1'b0;
        end else begin
            meas_start <= 1'b0;
            if (!busy) begin
                if (trig) begin
                    busy       <= 1'b1;
                    meas_start <= 1'b1;
                    run_sw     <= sw_trig;
                end
            end else if (meas_done) begin
                if (pend || trig) begin
                    meas_start <= 1'b1;
                    run_sw     <= sw_req || (sw_trig && !pend);
                    sw_req     <= 1'b0;
                    pend       <= 1'b0;
                end else begin
                    busy   <= 1'b0;
                    run_sw <= 1'b0;
                end
            end else if (trig && !pend) begin
                pend   <= 1'b1;
                sw_req <= sw_trig;
            end
        end
    end
endmodule

// File: rtl/dlcal_regs.sv
// Register storage for the control and configuration words and the read
// multiplexer. A direct write of the actual delay takes precedence over a
// calibration result in the same cycle; the inhibit bit blocks results.
module dlcal_regs (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ctrl_wr,
    input  logic                              cfg_wr,
    input  dlcal_pkg::ctrl_t                  ctrl_in,
    input  logic [dlcal_pkg::FIELD_W-1:0]     tgt_in,
    input  logic [dlcal_pkg::FIELD_W-1:0]     act_in,
    input  logic                              res_valid,
    input  logic [dlcal_pkg::FIELD_W-1:0]     res_bufs,
    input  logic [dlcal_pkg::FIELD_W-1:0]     res_half,
    input  logic                              recal_busy,
    input  logic                              rd_sel,
    output dlcal_pkg::ctrl_t                  ctrl_q,
    output logic [dlcal_pkg::FIELD_W-1:0]     tgt_q,
    output logic [dlcal_pkg::FIELD_W-1:0]     act_q,
    output logic [dlcal_pkg::REG_W-1:0]       rdata
);
    import dlcal_pkg::*;

    logic [FIELD_W-1:0] bufs_q;
    logic [FIELD_W-1:0] half_q;

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_in;
        end
    end

    // Software target and hardware-measured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            bufs_q <= '0;
            half_q <= '0;
        end else begin
            if (cfg_wr) begin
                tgt_q <= tgt_in;
            end
            if (res_valid) begin
                bufs_q <= res_bufs;
                half_q <= res_half;
            end
        end
    end

    // Actual delay: direct write first, then an uninhibited result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (cfg_wr) begin
            act_q <= act_in;
        end else if (res_valid && !ctrl_q.inhibit) begin
            act_q <= res_bufs;
        end
    end

    // Read multiplexer with reserved control bits forced to zero
    always_comb begin
        if (rd_sel) begin
            rdata = {half_q, tgt_q, bufs_q, act_q};
        end else begin
            rdata = '0;
            rdata[B_RECAL] = recal_busy;
            rdata[B_USE]   = ctrl_q.use_act;
            rdata[B_AUTO]  = ctrl_q.auto_en;
            rdata[B_INH]   = ctrl_q.inhibit;
            rdata[1:0]     = ctrl_q.period;
        end
    end
endmodule

// File: rtl/dlcal_sched.sv
// Top of the delay-line calibration scheduler. Decodes register writes
// into triggers and field updates, combines the software and periodic
// trigger sources under the use-direct-delay override, and hands runs to
// an external measurement engine. Assumes single-cycle register writes.
module dlcal_sched #(
    parameter int P0 = 10000,
    parameter int P1 = 1000000,
    parameter int P2 = 10000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        meas_start,
    output logic [7:0]  meas_target,
    input  logic        meas_done,
    input  logic [7:0]  meas_bufs,
    input  logic [7:0]  meas_half,
    output logic [7:0]  dly_out
);
    import dlcal_pkg::*;

    logic   ctrl_wr;
    logic   cfg_wr;
    ctrl_t  ctrl_in;
    ctrl_t  ctrl_q;
    logic   sw_trig;
    logic   per_fire;
    logic   per_trig;
    logic   run_busy;
    logic   run_pend;
    logic   recal_busy;
    logic   res_valid;
    logic   wr_unused;

    assign ctrl_wr = reg_wr && !reg_addr;
    assign cfg_wr  = reg_wr &&  reg_addr;

    // Unpack a control write into the stored fields
    always_comb begin
        ctrl_in.use_act = reg_wdata[B_USE];
        ctrl_in.auto_en = reg_wdata[B_AUTO];
        ctrl_in.inhibit = reg_wdata[B_INH];
        ctrl_in.period  = per_code_e'(reg_wdata[1:0]);
    end

    assign wr_unused = ^{reg_wdata[31:24], reg_wdata[15:8], reg_wdata[3:2]};

    assign sw_trig   = ctrl_wr && reg_wdata[B_RECAL] && !reg_wdata[B_USE];
    assign per_trig  = per_fire && !ctrl_q.use_act;
    assign res_valid = meas_done && run_busy;

    dlcal_period_timer #(.P0(P0), .P1(P1), .P2(P2)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_q.auto_en),
        .period  (ctrl_q.period),
        .restart (ctrl_wr),
        .fire    (per_fire)
    );

    dlcal_run_ctrl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_trig    (sw_trig),
        .per_trig   (per_trig),
        .meas_done  (meas_done),
        .meas_start (meas_start),
        .busy       (run_busy),
        .pend       (run_pend),
        .recal_busy (recal_busy)
    );

    dlcal_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .cfg_wr     (cfg_wr),
        .ctrl_in    (ctrl_in),
        .tgt_in     (reg_wdata[23:16]),
        .act_in     (reg_wdata[7:0]),
        .res_valid  (res_valid),
        .res_bufs   (meas_bufs),
        .res_half   (meas_half),
        .recal_busy (recal_busy),
        .rd_sel     (reg_addr),
        .ctrl_q     (ctrl_q),
        .tgt_q      (meas_target),
        .act_q      (dly_out),
        .rdata      (reg_rdata)
    );
endmodule

// File: rtl/dlcal_sched_chk.sv
// Property checker for the calibration scheduler, attached by bind.
module dlcal_sched_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        meas_start,
    input logic        meas_done,
    input logic [7:0]  dly_out,
    input logic        ctrl_wr,
    input logic        cfg_wr,
    input logic        inhibit,
    input logic        use_act,
    input logic        run_busy
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[31:8] == 24'h0 && reg_rdata[3:2] == 2'b00)); // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |=> (!meas_start || $past(meas_done))); // R10

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !cfg_wr) |=> $stable(dly_out)); // R6

    AST_DIRECT_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_act && !run_busy && !ctrl_wr) |=> !meas_start); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (dly_out == $past(reg_wdata[7:0]))); // R11
endmodule

bind dlcal_sched dlcal_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .meas_start (meas_start),
    .meas_done  (meas_done),
    .dly_out    (dly_out),
    .ctrl_wr    (ctrl_wr),
    .cfg_wr     (cfg_wr),
    .inhibit    (ctrl_q.inhibit),
    .use_act    (ctrl_q.use_act),
    .run_busy   (run_busy)
);

// File: tb/dlcal_sched_test.sv
`timescale 1ns/1ps
module dlcal_sched_test;
    localparam int P0 = 8;
    localparam int P1 = 20;
    localparam int P2 = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        meas_start;
    logic [7:0]  meas_target;
    logic        meas_done = 1'b0;
    logic [7:0]  meas_bufs = '0;
    logic [7:0]  meas_half = '0;
    logic [7:0]  dly_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int lat = 3;
    int nstart = 0;
    int st_t [0:7];

    dlcal_sched #(.P0(P0), .P1(P1), .P2(P2)) uut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record start pulses shortly after each edge
    always @(posedge clk) begin
        #1;
        if (rst_n && meas_start) begin
            if (nstart < 8) st_t[nstart] = cyc;
            nstart = nstart + 1;
        end
    end

    function automatic logic [7:0] eb(input logic [7:0] t);
        return (t >> 1) + 8'd9;
    endfunction
    function automatic logic [7:0] eh(input logic [7:0] t);
        return t ^ 8'h5A;
    endfunction

    // Measurement engine stub: answers each start after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            while (meas_start) begin
                repeat (lat - 1) @(negedge clk);
                meas_bufs = eb(meas_target);
                meas_half = eh(meas_target);
                meas_done = 1'b1;
                @(negedge clk);
                meas_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a; #0.1; d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] r;
        int w;
        logic [7:0] hx, bx;
        wait_cyc(4);
        // R1 reset values
        rd(0, r); chk("R1 ctrl reset", r, 32'h21);
        rd(1, r); chk("R1 cfg reset", r, 32'h0);
        nstart = 0;
        rst_n = 1'b1;
        w = cyc;
        wait_cyc(P1 + 2);
        chk("R7 code01 after reset count", nstart, 1);
        chk("R7 code01 after reset time", st_t[0], w + P1);
        wait_cyc(5);
        wr(0, 32'h0);
        hx = eh(8'h00); bx = eb(8'h00);

        // R3 R4 R5 software sweep
        for (int i = 0; i < 18; i++) begin
            logic [7:0] t;
            t = 8'(i * 15);
            lat = 1 + (i % 6);
            wr(1, {8'hFF, t, 8'hEE, 8'h11});
            rd(1, r); chk("R5 cfg write", r, {hx, t, bx, 8'h11});
            chk("R5 target port", meas_target, t);
            nstart = 0;
            wr(0, 32'h80);
            w = cyc;
            rd(0, r); chk("R3 busy bit", r, 32'h80);
            chk("R3 start time", st_t[0], w);
            wait_cyc(lat + 2);
            rd(0, r); chk("R3 bit clears", r, 32'h0);
            hx = eh(t); bx = eb(t);
            rd(1, r); chk("R4 result", r, {hx, t, bx, bx});
            chk("R4 dly_out", dly_out, bx);
            chk("R3 one start", nstart, 1);
        end

        // R6 inhibit
        lat = 3;
        wr(1, {8'h00, 8'h40, 8'h00, 8'h33});
        wr(0, 32'h90);
        wait_cyc(8);
        rd(1, r); chk("R6 inhibit", r, {eh(8'h40), 8'h40, eb(8'h40), 8'h33});
        chk("R6 dly_out held", dly_out, 8'h33);
        rd(0, r); chk("R6 ctrl", r, 32'h10);

        // R11 direct write collides with completion
        lat = 4;
        wr(0, 32'h80);
        wait_cyc(3);
        wr(1, {8'h00, 8'h40, 8'h00, 8'h77});
        wait_cyc(3);
        chk("R11 write wins", dly_out, 8'h77);
        rd(1, r); chk("R11 bufs still updated", r[15:8], eb(8'h40));

        // R2 reserved bits
        nstart = 0;
        wr(0, 32'hFFFF_FF7F);
        rd(0, r); chk("R2 reserved read", r, 32'h73);
        wait_cyc(10);
        chk("R2 no start", nstart, 0);
        wr(0, 32'h0);

        // R9 direct delay suppresses triggers
        nstart = 0;
        wr(0, 32'hC0);
        rd(0, r); chk("R9 recal bit", r, 32'h40);
        wait_cyc(20);
        wr(0, 32'h60);
        wait_cyc(3 * P0);
        chk("R9 no starts", nstart, 0);
        wr(0, 32'h0);

        // R7 period codes
        lat = 3;
        for (int c = 0; c < 3; c++) begin
            int p;
            p = (c == 0) ? P0 : (c == 1) ? P1 : P2;
            nstart = 0;
            wr(0, 32'h20 | c);
            w = cyc;
            wait_cyc(2 * p + 2);
            chk("R7 start count", nstart, 2);
            chk("R7 first start", st_t[0], w + p);
            chk("R7 interval", st_t[1] - st_t[0], p);
            wr(0, 32'h0);
            wait_cyc(5);
        end
        nstart = 0;
        wr(0, 32'h23);
        wait_cyc(2 * P2);
        chk("R7 code11 silent", nstart, 0);
        wr(0, 32'h0);

        // R8 restart on rewrite
        wait_cyc(5);
        wr(0, 32'h21);
        wait_cyc(10);
        nstart = 0;
        wr(0, 32'h21);
        w = cyc;
        wait_cyc(P1 + 2);
        chk("R8 restart", st_t[0], w + P1);
        wr(0, 32'h0);
        wait_cyc(5);

        // R10 periodic queue with drops
        lat = 20;
        nstart = 0;
        wr(0, 32'h20);
        w = cyc;
        wait_cyc(52);
        chk("R10 first", st_t[0], w + P0);
        chk("R10 queued", st_t[1], w + P0 + 20);
        chk("R10 dropped", st_t[2], w + P0 + 40);
        wr(0, 32'h0);
        wait_cyc(45);

        // R10 software queue
        lat = 30;
        nstart = 0;
        wr(0, 32'h80);
        w = cyc;
        wr(0, 32'h80);
        wr(0, 32'h80);
        rd(0, r); chk("R10 sw busy", r, 32'h80);
        wait_cyc(35);
        rd(0, r); chk("R10 sw second busy", r, 32'h80);
        chk("R10 sw second start", st_t[1], w + 30);
        wait_cyc(30);
        chk("R10 sw count", nstart, 2);
        rd(0, r); chk("R10 sw done", r, 32'h0);

        summary();
    end
endmodule